// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers every interrupt cause of a UART, ranks them, and presents the most urgent pending one as a 4-bit identification code together with an interrupt request line. Error, timeout and modem-change events are held in sticky flags until the matching register read clears them. Receive data availability is shown as a live level, taken either from the "data present" flag or from the FIFO trigger flag, depending on whether the FIFOs are on. Each source has its own enable. A disabled source is not shown, but its sticky flag still records the event.

The transmit-empty cause has its own qualifier. When the transmit FIFO becomes empty and has held two or more characters at once since the last empty event, the interrupt is raised at once. Otherwise it is raised only after one character time minus the stop bit, counted in 16x baud-tick enables, and a write to the transmit holding register during that wait cancels it. This keeps start-up from producing a burst of transmit-empty interrupts while software is still filling the FIFO. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the code is 4'b0001 and `irq` is 0. Whenever a code is shown, `irq` equals the inverse of code bit 0. Codes: none 0001, line status 0110, receive data 0100, timeout 1100, transmit empty 0010, modem status 0000.
- R2: When several sources are pending, the code shown is the first pending one in this order: line status, receive data, timeout, transmit empty, modem status.
- R3: A cycle with `err_overrun`, `err_parity` or `err_framing` high makes line status pending from the next cycle. A `rd_lsr` strobe clears it. If an error and `rd_lsr` come in the same cycle, the flag stays set.
- R4: Receive data is pending combinationally. With `fifo_on`=1 it follows `rx_trig`. With `fifo_on`=0 it follows `rx_avail`.
- R5: A `rx_timeout` pulse makes timeout pending from the next cycle. A `rd_rbr` strobe clears it.
- R6: When `tx_empty` rises and `tx_level` has been 2 or more since the last transmit-empty event, transmit empty is pending from the next cycle.
- R7: In any other case transmit empty becomes pending only after OS_RATE*(6+`word_len`+`parity_on`) baud ticks (`word_len` 0..3 selects 5..8 data bits). The count starts the cycle after the rise. A `wr_thr` strobe during the wait cancels it.
- R8: A `wr_thr` strobe clears transmit empty. A `rd_iir` strobe clears it only when code 0010 is shown in that cycle.
- R9: A `cts_edge` pulse makes modem status pending from the next cycle. A `rd_msr` strobe clears it.
- R10: A source whose enable is 0 is not shown. Its sticky flag keeps recording, so setting the enable shows a pending event at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_line | input | 1 | Enable for line status |
| en_rxd | input | 1 | Enable for receive data available |
| en_tmo | input | 1 | Enable for character timeout |
| en_txe | input | 1 | Enable for transmit empty |
| en_mdm | input | 1 | Enable for modem status |
| err_overrun | input | 1 | Overrun error event |
| err_parity | input | 1 | Parity error event |
| err_framing | input | 1 | Framing error event |
| rx_avail | input | 1 | Receive data present |
| fifo_on | input | 1 | FIFOs enabled |
| rx_trig | input | 1 | Receive FIFO level at or above trigger |
| rx_timeout | input | 1 | Character timeout event pulse |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_level | input | TXL_W | Transmit FIFO fill level |
| cts_edge | input | 1 | CTS transition pulse |
| baud_tick | input | 1 | 16x baud tick enable |
| word_len | input | 2 | Data bits minus 5 |
| parity_on | input | 1 | Parity bit present |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| irq_id | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same cycle: setting a sticky flag and clearing it by a read. The bench drives a framing error in the same cycle as `rd_lsr` and expects line status to remain shown. It also reads the identification register while line status hides a pending transmit-empty cause, and expects transmit empty to survive that read and appear after `rd_lsr`. A third case pulses CTS while transmit empty is shown and expects the code to stay at transmit empty until `wr_thr` clears it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  typedef enum logic [3:0] {
    ID_NONE = 4'b0001,
    ID_LINE = 4'b0110,
    ID_RXD  = 4'b0100,
    ID_TMO  = 4'b1100,
    ID_TXE  = 4'b0010,
    ID_MDM  = 4'b0000
  } irq_code_e;

  localparam int NUM_STICKY = 3;
  localparam int MIN_CHAR_BITS = 6;  // start bit plus five data bits
  localparam int MAX_CHAR_BITS = 10; // start, eight data, parity
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/uirq_txe_qual.sv
module uirq_txe_qual #(
  parameter int OS_RATE = 16,
  parameter int TXL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_empty,
  input  logic [TXL_W-1:0] tx_level,
  input  logic [1:0]       word_len,
  input  logic             parity_on,
  input  logic             baud_tick,
  input  logic             wr_thr,
  input  logic             shown_clr,
  output logic             txe_pend
);
  import uirq_pkg::*;
  localparam int CNT_W = $clog2(OS_RATE * MAX_CHAR_BITS + 1);

  logic             empty_q, two_seen, waiting, empty_rise;
  logic [CNT_W-1:0] tick_cnt, tick_lim;
  logic [3:0]       char_bits;

  assign empty_rise = tx_empty & ~empty_q;
  assign char_bits  = 4'(MIN_CHAR_BITS) + {2'b00, word_len} + {3'b000, parity_on};
  assign tick_lim   = CNT_W'(OS_RATE) * CNT_W'(char_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q  <= 1'b0;
      two_seen <= 1'b0;
      waiting  <= 1'b0;
      tick_cnt <= '0;
      txe_pend <= 1'b0;
    end else begin
      empty_q <= tx_empty;
      if (tx_level >= TXL_W'(2)) two_seen <= 1'b1;
      if (wr_thr || shown_clr) begin
        txe_pend <= 1'b0;
        waiting  <= 1'b0;
      end else if (empty_rise) begin
        if (two_seen) begin
          txe_pend <= 1'b1;
          two_seen <= 1'b0;
        end else begin
          waiting  <= 1'b1;
          tick_cnt <= '0;
        end
      end else if (waiting) begin
        if (!tx_empty) begin
          waiting <= 1'b0;
        end else if (baud_tick) begin
          if (tick_cnt == tick_lim - CNT_W'(1)) begin
            txe_pend <= 1'b1;
            waiting  <= 1'b0;
            two_seen <= 1'b0;
          end else begin
            tick_cnt <= tick_cnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/uirq_rank.sv
module uirq_rank (
  input  logic               line_i,
  input  logic               rxd_i,
  input  logic               tmo_i,
  input  logic               txe_i,
  input  logic               mdm_i,
  output uirq_pkg::irq_code_e code_o
);
  import uirq_pkg::*;
  always_comb begin
    if      (line_i) code_o = ID_LINE;
    else if (rxd_i)  code_o = ID_RXD;
    else if (tmo_i)  code_o = ID_TMO;
    else if (txe_i)  code_o = ID_TXE;
    else if (mdm_i)  code_o = ID_MDM;
    else             code_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter int OS_RATE = 16,
  parameter int TXL_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_line,
  input  logic             en_rxd,
  input  logic             en_tmo,
  input  logic             en_txe,
  input  logic             en_mdm,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             rx_avail,
  input  logic             fifo_on,
  input  logic             rx_trig,
  input  logic             rx_timeout,
  input  logic             tx_empty,
  input  logic [TXL_W-1:0] tx_level,
  input  logic             cts_edge,
  input  logic             baud_tick,
  input  logic [1:0]       word_len,
  input  logic             parity_on,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  input  logic             wr_thr,
  output logic [3:0]       irq_id,
  output logic             irq
);
  import uirq_pkg::*;

  logic [NUM_STICKY-1:0] st_set, st_clr, st_flag;
  logic      txe_pend, shown_clr, rxd_lvl;
  irq_code_e code;

  // index 0: line status, 1: timeout, 2: modem status
  assign st_set = {cts_edge, rx_timeout, err_overrun | err_parity | err_framing};
  assign st_clr = {rd_msr, rd_rbr, rd_lsr};

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    uirq_sticky u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[i]),
      .clr_i (st_clr[i]),
      .flag_o(st_flag[i])
    );
  end

  assign shown_clr = rd_iir && (code == ID_TXE);

  uirq_txe_qual #(.OS_RATE(OS_RATE), .TXL_W(TXL_W)) u_txe (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_empty (tx_empty),
    .tx_level (tx_level),
    .word_len (word_len),
    .parity_on(parity_on),
    .baud_tick(baud_tick),
    .wr_thr   (wr_thr),
    .shown_clr(shown_clr),
    .txe_pend (txe_pend)
  );

  assign rxd_lvl = fifo_on ? rx_trig : rx_avail;

  uirq_rank u_rank (
    .line_i(st_flag[0] & en_line),
    .rxd_i (rxd_lvl & en_rxd),
    .tmo_i (st_flag[1] & en_tmo),
    .txe_i (txe_pend & en_txe),
    .mdm_i (st_flag[2] & en_mdm),
    .code_o(code)
  );

  assign irq_id = code;
  assign irq    = ~code[0];
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_line,
  input logic       en_mdm,
  input logic       err_any,
  input logic       rd_lsr,
  input logic       rd_iir,
  input logic       wr_thr,
  input logic       cts_edge,
  input logic [3:0] irq_id,
  input logic       irq
);
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});

  p_line_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && en_line) |=> (irq_id == 4'b0110));

  p_line_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !err_any) |=> (irq_id != 4'b0110));

  p_txe_wr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> (irq_id != 4'b0010));

  p_txe_iir_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && irq_id == 4'b0010) |=> (irq_id != 4'b0010));

  p_mdm_raise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_edge && en_mdm) |=> irq);
endmodule

bind uart_irq_ident uirq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_line (en_line),
  .en_mdm  (en_mdm),
  .err_any (err_overrun | err_parity | err_framing),
  .rd_lsr  (rd_lsr),
  .rd_iir  (rd_iir),
  .wr_thr  (wr_thr),
  .cts_edge(cts_edge),
  .irq_id  (irq_id),
  .irq     (irq)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  localparam int TXL_W = 5;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en_line = 1, en_rxd = 1, en_tmo = 1, en_txe = 1, en_mdm = 1;
  logic err_overrun = 0, err_parity = 0, err_framing = 0;
  logic rx_avail = 0, fifo_on = 0, rx_trig = 0, rx_timeout = 0;
  logic tx_empty = 0, cts_edge = 0, baud_tick = 0, parity_on = 0;
  logic [TXL_W-1:0] tx_level = '0;
  logic [1:0] word_len = 2'd0;
  logic rd_lsr = 0, rd_rbr = 0, rd_iir = 0, rd_msr = 0, wr_thr = 0;
  logic [3:0] irq_id;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.OS_RATE(16), .TXL_W(TXL_W)) u0 (.*);

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string tag, logic [3:0] exp);
    checks++;
    if (irq_id !== exp || irq !== ~exp[0]) begin
      errors++;
      $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b", tag, irq_id, irq, exp, ~exp[0]);
    end
  endtask

  task automatic t_reset;
    check("R1 reset idle", 4'b0001);
  endtask

  task automatic t_line;
    err_parity = 1; tick(); err_parity = 0;
    check("R3 parity error raises line status", 4'b0110);
    rd_lsr = 1; tick(); rd_lsr = 0;
    check("R3 rd_lsr clears", 4'b0001);
    err_overrun = 1; tick(); err_overrun = 0;
    err_framing = 1; rd_lsr = 1; tick(); err_framing = 0; rd_lsr = 0;
    check("R3 error with rd_lsr in same cycle keeps flag", 4'b0110);
    rd_lsr = 1; tick(); rd_lsr = 0;
    check("R3 cleared again", 4'b0001);
  endtask

  task automatic t_rxd;
    rx_avail = 1; #1;
    check("R4 fifo off follows rx_avail", 4'b0100);
    fifo_on = 1; #1;
    check("R4 fifo on ignores rx_avail", 4'b0001);
    rx_trig = 1; #1;
    check("R4 fifo on follows rx_trig", 4'b0100);
    rx_trig = 0; rx_avail = 0; fifo_on = 0;
    tick();
  endtask

  task automatic t_tmo_prio;
    rx_timeout = 1; tick(); rx_timeout = 0;
    check("R5 timeout raised", 4'b1100);
    rx_avail = 1; #1;
    check("R2 receive data over timeout", 4'b0100);
    err_framing = 1; tick(); err_framing = 0;
    check("R2 line status over receive data", 4'b0110);
    rd_lsr = 1; tick(); rd_lsr = 0; rx_avail = 0;
    rd_rbr = 1; tick(); rd_rbr = 0;
    check("R5 rd_rbr clears timeout", 4'b0001);
  endtask

  task automatic t_mdm;
    en_mdm = 0; cts_edge = 1; tick(); cts_edge = 0;
    check("R10 disabled modem status hidden", 4'b0001);
    en_mdm = 1; #1;
    check("R10 enable reveals recorded event", 4'b0000);
    rd_msr = 1; tick(); rd_msr = 0;
    check("R9 rd_msr clears", 4'b0001);
    cts_edge = 1; tick(); cts_edge = 0;
    check("R9 cts edge raises modem status", 4'b0000);
    rd_msr = 1; tick(); rd_msr = 0;
  endtask

  task automatic t_txe_fast;
    tx_level = 5'd3; tick();
    tx_level = 5'd0; tx_empty = 1; tick();
    check("R6 immediate after two held", 4'b0010);
    rd_iir = 1; tick(); rd_iir = 0;
    check("R8 rd_iir clears shown txe", 4'b0001);
    tx_empty = 0; tick();
  endtask

  task automatic t_txe_delay;
    word_len = 2'd0; parity_on = 0; baud_tick = 1;
    tx_empty = 1; tick(96);
    check("R7 not yet raised after 95 ticks", 4'b0001);
    tick();
    check("R7 raised after 96 ticks", 4'b0010);
    err_overrun = 1; tick(); err_overrun = 0;
    rd_iir = 1; tick(); rd_iir = 0;
    rd_lsr = 1; tick(); rd_lsr = 0;
    check("R8 rd_iir while line shown keeps txe", 4'b0010);
    cts_edge = 1; tick(); cts_edge = 0;
    check("R2 txe over modem status", 4'b0010);
    wr_thr = 1; tick(); wr_thr = 0;
    check("R8 wr_thr clears txe", 4'b0000);
    rd_msr = 1; tick(); rd_msr = 0;
    tx_empty = 0; tick();
  endtask

  task automatic t_txe_cancel;
    word_len = 2'd3; parity_on = 1;
    tx_empty = 1; tick(50);
    wr_thr = 1; tick(); wr_thr = 0;
    tick(200);
    check("R7 write cancels pending delay", 4'b0001);
    tx_empty = 0; tick();
    tx_empty = 1; tick(160);
    check("R7 eight bits plus parity not yet", 4'b0001);
    tick();
    check("R7 eight bits plus parity after 160 ticks", 4'b0010);
    wr_thr = 1; tick(); wr_thr = 0;
    tx_empty = 0; baud_tick = 0; tick();
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    t_reset();
    t_line();
    t_rxd();
    t_tmo_prio();
    t_mdm();
    t_txe_fast();
    t_txe_delay();
    t_txe_cancel();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: bench did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule